// File: doc/BRIEF.md
# Byte-lane controller for an asynchronous static RAM

This block sits between a clocked host and an external asynchronous static RAM of 131072 sixteen-bit words. The host offers one request at a time over a valid/ready handshake. A request carries a 17-bit word address, 16 bits of write data, a read/write flag and one enable bit per byte lane. The controller turns each request into a sequence of memory strobes that all come from registers. Every phase lasts a whole number of clock cycles, and each count is a ceiling division of a nanosecond limit by the clock period.

A read holds chip select and output enable low for the access window. It samples the bus in the last cycle of that window and returns the word with a one-cycle valid pulse. After every read the controller keeps the bus quiet so that the memory's output drivers can switch off. A write holds chip select and write enable low and drives the data bus for the write window. It then keeps the address and data for one more cycle with all strobes released. A request whose two lane enables are both clear is accepted at once, with no strobes and no read return.

Top module: `sram_lane_ctrl`

## Requirements
- R1: During and after reset, all five memory strobes are high (inactive), the bus drive enable is low, the read-valid pulse is low and the host ready is high.
- R2: A read holds chip select and output enable low, with write enable high, for RD = ceil(70 ns / clock period) cycles; 7 cycles at 10 ns.
- R3: Read data is sampled in the last cycle of the read window. It appears with a read-valid pulse of exactly one cycle, the cycle after that window ends (8 clock edges after acceptance at 10 ns).
- R4: A write holds chip select and write enable low, with output enable high and the data bus driven, for WR = ceil(70 ns / clock period) cycles; 7 at 10 ns. The write-enable low pulse is therefore never shorter than 55 ns.
- R5: Lane enable bit 0 drives the lower strobe low and gates data bits 7:0; bit 1 drives the upper strobe low and gates bits 15:8. Only enabled lanes are written, and lanes not enabled on a read return zero.
- R6: The data bus is driven only while write enable is low and for one hold cycle after it rises. It is never driven while output enable is low.
- R7: After a read, the bus stays undriven and all strobes stay high for at least TA = ceil(30 ns / clock period) cycles (3 at 10 ns) before any further access.
- R8: A request with both lane enables clear is accepted, asserts no strobe, produces no read-valid pulse, leaves memory unchanged, and ready is high again in the next cycle.
- R9: The memory address equals the request address and stays stable while chip select is low.
- R10: Host ready is low from acceptance until the access and its trailing quiet or hold cycles end (11 edges for a read, 9 for a write at 10 ns). While ready is high, no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane enables, bit 0 lower byte, bit 1 upper byte |
| rd_valid | output | 1 | One-cycle read return pulse |
| rd_data | output | 16 | Read return word, disabled lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_dq_o | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data returned from memory |

## Verification
A phase counter loaded with a wrong value shows up at the pins. A read window cut short makes the bench's memory model return garbage, which corrupts rd_data in the very transaction affected. A write pulse too short stops that model from committing, so the word read back later is wrong. A missing or short quiet gap after a read is flagged by the bus monitor in the first cycle of the next access. A wrong lane mapping or a stuck state shows as bad data, wrong strobe levels or a ready that never returns, within one request.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int CLK_NS      = 10,
  parameter int T_CYCLE_NS  = 70,
  parameter int T_OE_NS     = 35,
  parameter int T_WP_NS     = 55,
  parameter int T_SETUP_NS  = 60,
  parameter int T_DW_NS     = 40,
  parameter int T_HZ_NS     = 30,
  parameter int AW          = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_be,
  output logic          rd_valid,
  output logic [15:0]   rd_data,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [15:0]   mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_i
);

  localparam int RD_NS  = (T_CYCLE_NS > T_OE_NS) ? T_CYCLE_NS : T_OE_NS;
  localparam int W1_NS  = (T_CYCLE_NS > T_WP_NS) ? T_CYCLE_NS : T_WP_NS;
  localparam int W2_NS  = (T_SETUP_NS > T_DW_NS) ? T_SETUP_NS : T_DW_NS;
  localparam int WR_NS  = (W1_NS > W2_NS) ? W1_NS : W2_NS;
  localparam int RD_CYC = (RD_NS + CLK_NS - 1) / CLK_NS;
  localparam int WR_CYC = (WR_NS + CLK_NS - 1) / CLK_NS;
  localparam int TA_RAW = (T_HZ_NS + CLK_NS - 1) / CLK_NS;
  localparam int TA_CYC = (TA_RAW < 1) ? 1 : TA_RAW;
  localparam int MAXC   = (RD_CYC > WR_CYC) ? ((RD_CYC > TA_CYC) ? RD_CYC : TA_CYC)
                                            : ((WR_CYC > TA_CYC) ? WR_CYC : TA_CYC);
  localparam int CW     = $clog2(MAXC + 1);

  if (CLK_NS < 1) begin : g_bad_clk
    $error("clock period must be positive");
  end
  if (RD_CYC * CLK_NS < RD_NS || WR_CYC * CLK_NS < T_WP_NS || TA_CYC * CLK_NS < T_HZ_NS) begin : g_bad_cnt
    $error("derived phase counts violate memory timing");
  end

  typedef enum logic [2:0] {S_IDLE, S_READ, S_TURN, S_WRITE, S_HOLD} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic          last;

  assign last      = (cnt == '0);
  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      mem_addr  <= '0;
      mem_cs_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid && req_be != 2'b00) begin
            mem_addr <= req_addr;
            mem_cs_n <= 1'b0;
            mem_lb_n <= ~req_be[0];
            mem_ub_n <= ~req_be[1];
            if (req_write) begin
              mem_we_n  <= 1'b0;
              mem_dq_o  <= req_wdata;
              mem_dq_oe <= 1'b1;
              cnt       <= CW'(WR_CYC - 1);
              state     <= S_WRITE;
            end else begin
              mem_oe_n <= 1'b0;
              cnt      <= CW'(RD_CYC - 1);
              state    <= S_READ;
            end
          end
        end
        S_READ: begin
          if (last) begin
            rd_data  <= {mem_ub_n ? 8'h00 : mem_dq_i[15:8],
                         mem_lb_n ? 8'h00 : mem_dq_i[7:0]};
            rd_valid <= 1'b1;
            mem_cs_n <= 1'b1;
            mem_oe_n <= 1'b1;
            mem_lb_n <= 1'b1;
            mem_ub_n <= 1'b1;
            cnt      <= CW'(TA_CYC - 1);
            state    <= S_TURN;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_TURN: begin
          if (last) state <= S_IDLE;
          else      cnt   <= cnt - 1'b1;
        end
        S_WRITE: begin
          if (last) begin
            mem_we_n <= 1'b1;
            mem_cs_n <= 1'b1;
            mem_lb_n <= 1'b1;
            mem_ub_n <= 1'b1;
            state    <= S_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_HOLD: begin
          mem_dq_oe <= 1'b0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_read_strobes_R2: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_cs_n));

  assert_write_strobes_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_cs_n && mem_oe_n && mem_dq_oe));

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  assert_lane_active_R5: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> (!mem_lb_n || !mem_ub_n));

  assert_no_drive_on_read_R6: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !$past(mem_cs_n)) |-> $stable(mem_addr));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
  localparam int RD = 7, WR = 7, TA = 3, WP_MIN = 6;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rd_valid, mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [15:0] rd_data, mem_dq_o, mem_dq_i;
  logic [16:0] mem_addr;

  always #5 clk = ~clk;

  sram_lane_ctrl uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int checks = 0, errors = 0, mchecks = 0, merrs = 0;
  bit done = 0;
  logic [15:0] dev_m [int];
  logic [15:0] ref_m [int];
  logic [16:0] cur_addr = '0;
  logic [1:0]  cur_be = '0;

  function automatic logic [15:0] initv(input logic [16:0] a);
    return a[15:0] ^ 16'h3C3C;
  endfunction
  function automatic logic [15:0] dev_rd(input logic [16:0] a);
    return dev_m.exists(int'(a)) ? dev_m[int'(a)] : initv(a);
  endfunction
  function automatic logic [15:0] ref_rd(input logic [16:0] a);
    return ref_m.exists(int'(a)) ? ref_m[int'(a)] : initv(a);
  endfunction
  function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] n, input logic [1:0] be);
    return {be[1] ? n[15:8] : o[15:8], be[0] ? n[7:0] : o[7:0]};
  endfunction
  function automatic logic [15:0] exp_read(input logic [16:0] a, input logic [1:0] be);
    logic [15:0] w = ref_rd(a);
    return {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Memory model and bus monitor, evaluated away from the active edge
  int rd_cnt = 0, wp_cnt = 0, quiet = 0;
  bit after_read = 0, p_wact = 0, p_dqoe = 0;
  logic [16:0] p_addr;
  logic [15:0] p_data;
  logic [1:0]  p_lanes;
  initial mem_dq_i = 16'h0;
  always @(negedge clk) begin
    if (!rst) begin
      logic [15:0] w;
      bit wact;
      wact = !mem_cs_n && !mem_we_n;
      if (!wact && p_wact) begin
        mchecks++;
        if (wp_cnt < WP_MIN || !p_dqoe) begin
          merrs++;
          $display("FAIL R4: write pulse %0d cycles expected >= %0d", wp_cnt, WP_MIN);
        end else begin
          w = dev_rd(p_addr);
          dev_m[int'(p_addr)] = merge(w, p_data, ~p_lanes);
        end
      end
      wp_cnt = wact ? wp_cnt + 1 : 0;
      p_wact = wact; p_dqoe = mem_dq_oe; p_addr = mem_addr; p_data = mem_dq_o;
      p_lanes = {mem_ub_n, mem_lb_n};
      if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
        rd_cnt++;
        after_read = 1; quiet = 0;
      end else begin
        rd_cnt = 0;
        if (after_read) begin
          if (mem_cs_n && !mem_dq_oe) quiet++;
          else begin
            mchecks++;
            if (quiet < TA) begin
              merrs++;
              $display("FAIL R7: quiet cycles %0d expected >= %0d", quiet, TA);
            end
            after_read = 0;
          end
        end
      end
      if (mem_dq_oe && !mem_oe_n) begin
        merrs++;
        $display("FAIL R6: bus driven with output enable low, actual 1 expected 0");
      end
      if (!mem_cs_n) begin
        if (mem_addr !== cur_addr || {mem_ub_n, mem_lb_n} !== ~cur_be) begin
          merrs++;
          $display("FAIL R9/R5: addr %h lanes %b expected %h %b", mem_addr, {mem_ub_n, mem_lb_n}, cur_addr, ~cur_be);
        end
      end
      w = dev_rd(mem_addr);
      mem_dq_i = {(!mem_ub_n && rd_cnt >= RD) ? w[15:8] : 8'hA5,
                  (!mem_lb_n && rd_cnt >= RD) ? w[7:0]  : 8'h5A};
    end
  end

  task automatic issue(input bit wr, input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    if (be != 2'b00) begin cur_addr = a; cur_be = be; end
    @(posedge clk);
  endtask

  task automatic do_write(input logic [16:0] a, input logic [15:0] d, input logic [1:0] be);
    int n = 0;
    issue(1, a, d, be);
    if (be != 2'b00) ref_m[int'(a)] = merge(ref_rd(a), d, be);
    @(negedge clk); n = 1;
    req_valid = 0;
    if (be != 2'b00) check("R10 ready low during write", req_ready, 0);
    while (!req_ready && n < 40) begin @(negedge clk); n++; end
    check("R10 write busy length", n, (be == 2'b00) ? 1 : WR + 2);
    if (be != 2'b00) check("R4 R5 stored word", dev_rd(a), ref_rd(a));
  endtask

  task automatic do_read(input logic [16:0] a, input logic [1:0] be);
    int n = 0;
    logic [15:0] e = exp_read(a, be);
    issue(0, a, 16'h0, be);
    @(negedge clk); n = 1;
    req_valid = 0;
    while (!rd_valid && n < 40) begin
      check("R10 ready low during read", req_ready, 0);
      @(negedge clk); n++;
    end
    check("R2 R3 read return edge", n, RD + 1);
    check("R3 R5 read data", rd_data, e);
    @(negedge clk); n++;
    check("R3 pulse one cycle", rd_valid, 0);
    while (!req_ready && n < 40) begin @(negedge clk); n++; end
    check("R7 R10 read busy length", n, RD + TA + 1);
  endtask

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 strobes", {mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'b11111);
    check("R1 drive/valid/ready", {mem_dq_oe, rd_valid, req_ready}, 3'b001);
    rst = 0;
    @(negedge clk);
    check("R1 after release", {mem_cs_n, mem_dq_oe, req_ready}, 3'b101);

    do_write(17'h00000, 16'hBEEF, 2'b11);
    do_read(17'h00000, 2'b11);
    do_write(17'h1FFFF, 16'h1234, 2'b01);
    do_read(17'h1FFFF, 2'b11);
    do_write(17'h1FFFF, 16'hAB00, 2'b10);
    do_read(17'h1FFFF, 2'b01);
    do_read(17'h1FFFF, 2'b10);
    do_read(17'h00000, 2'b11);
    do_write(17'h00000, 16'h0F0F, 2'b11);

    // R8: empty lane request
    issue(1, 17'h00000, 16'hFFFF, 2'b00);
    @(negedge clk);
    req_valid = 0;
    check("R8 ready at once", req_ready, 1);
    n = 0;
    repeat (3) begin
      if (!mem_cs_n || rd_valid || mem_dq_oe) n++;
      @(negedge clk);
    end
    check("R8 no strobes or pulse", n, 0);
    issue(0, 17'h00123, 16'h0, 2'b00);
    @(negedge clk);
    req_valid = 0;
    check("R8 read no pulse", {rd_valid, req_ready, mem_cs_n}, 3'b011);
    do_read(17'h00000, 2'b11);

    for (int i = 0; i < 300; i++) begin
      logic [16:0] a = 17'((($urandom % 12) * 17'h2B59) & 17'h1FFFF);
      logic [1:0]  be = 2'($urandom % 4);
      if ($urandom % 2) do_write(a, 16'($urandom), be);
      else if (be == 2'b00) do_write(a, 16'h0, be);
      else do_read(a, be);
    end

    done = 1;
    checks += mchecks; errors += merrs;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks += mchecks + 1; errors += merrs + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule